// File: doc/BRIEF.md
# DMA Burst Transfer-Count Limiter

This block caps the number of data transfers a bus master makes during one DMA bus tenure. Software programs a transfer budget through a small register port. A write or read is accepted only while the controller's stop bit is set. Each new tenure begins with a grant-rise pulse, which reloads a down-counter from the programmed budget. After that, every transfer strobe takes one from the count. When the count reaches zero and the master is not partway through a linear burst, the block raises a one-cycle release request. If the master is partway through a linear burst, the request waits until the transfer address returns to a burst-start boundary.

Two control inputs change how the block behaves. The first is a mode bit that turns the limiter off, so the master may keep the bus. The second is a test bit: with it set, a register write takes one from the live count and does not load a new budget. When linear burst writes are enabled, a budget below four cannot be honoured. Such a value is clamped to four and flagged. The arbitration protocol, the data path and the FIFO are handled elsewhere.

Top module: `dma_tenure_limiter`

## Requirements
- R1: Hard reset (`rst`) or soft reset (`sw_rst`) sets the programmed budget and the live count to 16. It also clears `prog_err` and `release_req`.
- R2: A register write made while `stop` is 0 is ignored. It changes neither the budget nor the live count.
- R3: When `reg_rd` is high and `stop` is 1, `reg_rdata` shows the live remaining count on the following cycle. At all other times `reg_rdata` holds its value.
- R4: A write with `test_en` = 0 loads the written value into both the budget and the live count. If `lb_en` = 1 and the value is below 4, the block loads 4 and sets `prog_err`. Any other such write clears `prog_err`.
- R5: A write with `test_en` = 1 takes one from the live count, which stops at zero. The programmed budget is left unchanged.
- R6: A `grant_rise` pulse reloads the live count from the programmed budget and opens a tenure.
- R7: Each `xfer` strobe takes one from the live count while it is non-zero.
- R8: If `lb_en` = 0, `release_req` goes high on the clock edge at which an open tenure's live count is already zero.
- R9: If `lb_en` = 1, release also needs `xfer_addr` (counted in transfers) to be a multiple of the burst length. The length is set by `lb_sel`: 0 selects 2, 1 selects 4, and 2 or 3 select 8.
- R10: `release_req` is high for exactly one cycle and closes the tenure. No further release happens until the next `grant_rise`.
- R11: While `dmaplus_mode` = 1, `release_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| sw_rst | input | 1 | Synchronous soft reset, active high |
| stop | input | 1 | Controller stop bit; enables register access |
| dmaplus_mode | input | 1 | Disables the limiter |
| test_en | input | 1 | Register writes decrement the count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data (transfer budget) |
| reg_rdata | output | 16 | Registered read data (live count) |
| lb_en | input | 1 | Linear burst enable |
| lb_sel | input | 2 | Burst length select |
| grant_rise | input | 1 | Start of a new bus tenure |
| xfer | input | 1 | One data transfer made this cycle |
| xfer_addr | input | 8 | Current transfer address in transfer units |
| release_req | output | 1 | One-cycle request to give up the bus |
| prog_err | output | 1 | Last budget write was clamped |

## Verification
The release timing is swept over budgets from 4 to 12 and burst start offsets from 0 to 7, for every burst length, with linear bursting both on and off. With bursting off, the sweep confirms that release depends only on the count. With bursting on, it separates the deferral to the next aligned address from an early release at count zero. Further patterns cover the register port: writes and reads while the stop bit is clear, a clamped small budget compared with the same value unclamped, and a test-mode write compared with a normal load. Each pattern shows whether the port loads, decrements or ignores. Running the same tenure sweep with the disable mode set shows that the mode suppresses release.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic [1:0] {BL_2 = 2'd0, BL_4 = 2'd1, BL_8 = 2'd2, BL_8X = 2'd3} burst_sel_e;

  function automatic logic [3:0] burst_mask(input burst_sel_e sel);
    case (sel)
      BL_2:    burst_mask = 4'd1;
      BL_4:    burst_mask = 4'd3;
      default: burst_mask = 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/lim_cfg_reg.sv
module lim_cfg_reg #(
  parameter int CNT_W      = 16,
  parameter int RESET_CNT  = 16,
  parameter int MIN_LB_CNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] wdata,
  input  logic             lb_en,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] prog_q,
  output logic             err_q
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LB_CNT);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_CNT);

  logic too_small;
  assign too_small = lb_en && (wdata < MIN_V);
  assign load_val  = too_small ? MIN_V : wdata;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      prog_q <= RST_V;
      err_q  <= 1'b0;
    end else if (wr_load) begin
      prog_q <= load_val;
      err_q  <= too_small;
    end
  end
endmodule

// File: rtl/lim_down_counter.sv
module lim_down_counter #(
  parameter int CNT_W     = 16,
  parameter int RESET_CNT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_wr,
  input  logic             xfer,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero
);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_CNT);

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || sw_rst)
      cnt_q <= RST_V;
    else if (reload)
      cnt_q <= reload_val;
    else if (load)
      cnt_q <= load_val;
    else if ((dec_wr || xfer) && !zero)
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lim_align_chk.sv
module lim_align_chk #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        sel,
  output logic              aligned
);
  import lim_pkg::*;
  localparam int MW = (ADDR_W < 4) ? ADDR_W : 4;

  logic [3:0] mask;
  assign mask    = burst_mask(burst_sel_e'(sel));
  assign aligned = ((addr[MW-1:0] & mask[MW-1:0]) == '0);
endmodule

// File: rtl/dma_tenure_limiter.sv
module dma_tenure_limiter #(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int RESET_CNT  = 16,
  parameter int MIN_LB_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              stop,
  input  logic              dmaplus_mode,
  input  logic              test_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              lb_en,
  input  logic [1:0]        lb_sel,
  input  logic              grant_rise,
  input  logic              xfer,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              release_req,
  output logic              prog_err
);
  logic             wr_ok, wr_load, wr_dec;
  logic [CNT_W-1:0] load_val, prog_q, cnt_q;
  logic             cnt_zero, aligned, active_q, fire;

  assign wr_ok   = reg_wr && stop;
  assign wr_load = wr_ok && !test_en;
  assign wr_dec  = wr_ok && test_en;

  lim_cfg_reg #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT), .MIN_LB_CNT(MIN_LB_CNT)) u_cfg (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_load(wr_load), .wdata(reg_wdata),
    .lb_en(lb_en), .load_val(load_val), .prog_q(prog_q), .err_q(prog_err));

  lim_down_counter #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_cnt (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .reload(grant_rise), .reload_val(prog_q),
    .load(wr_load), .load_val(load_val), .dec_wr(wr_dec), .xfer(xfer),
    .cnt_q(cnt_q), .zero(cnt_zero));

  lim_align_chk #(.ADDR_W(ADDR_W)) u_aln (
    .addr(xfer_addr), .sel(lb_sel), .aligned(aligned));

  assign fire = active_q && cnt_zero && (!lb_en || aligned) && !dmaplus_mode && !grant_rise;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      active_q    <= 1'b0;
      release_req <= 1'b0;
    end else begin
      release_req <= fire;
      if (grant_rise)  active_q <= 1'b1;
      else if (fire)   active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 reg_rdata <= '0;
    else if (reg_rd && stop) reg_rdata <= cnt_q;
  end
endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
  parameter int CNT_W      = 16,
  parameter int RESET_CNT  = 16,
  parameter int MIN_LB_CNT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_rst,
  input logic             stop,
  input logic             dmaplus_mode,
  input logic             test_en,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] reg_rdata,
  input logic             lb_en,
  input logic             grant_rise,
  input logic             xfer,
  input logic             release_req,
  input logic             prog_err,
  input logic [CNT_W-1:0] cnt_q
);
  p_soft_reset_r1: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (cnt_q == CNT_W'(RESET_CNT) && !release_req && !prog_err));

  p_ignored_write_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !stop && !sw_rst && !grant_rise && !xfer) |=> $stable(cnt_q));

  p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && stop) |=> $stable(reg_rdata));

  p_clamp_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && stop && !test_en && lb_en && reg_wdata < CNT_W'(MIN_LB_CNT) && !sw_rst)
      |=> prog_err);

  p_test_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && stop && test_en && !sw_rst && !grant_rise && cnt_q != '0)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    release_req |=> !release_req);

  p_disable_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    dmaplus_mode |=> !release_req);
endmodule

bind dma_tenure_limiter lim_checker #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT), .MIN_LB_CNT(MIN_LB_CNT)) u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .stop(stop), .dmaplus_mode(dmaplus_mode),
  .test_en(test_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .lb_en(lb_en), .grant_rise(grant_rise), .xfer(xfer),
  .release_req(release_req), .prog_err(prog_err), .cnt_q(cnt_q));

// File: tb/sim_dma_tenure_limiter.sv
module sim_dma_tenure_limiter;
  logic clk = 1'b0;
  logic rst, sw_rst, stop, dmaplus_mode, test_en, reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic lb_en, grant_rise, xfer, release_req, prog_err;
  logic [1:0] lb_sel;
  logic [7:0] xfer_addr;
  int checks = 0, errors = 0, cyc_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_tenure_limiter u0 (.*);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    stop = 1; reg_wr = 1; reg_wdata = v; cyc(); reg_wr = 0;
  endtask

  task automatic rd(output int v);
    stop = 1; reg_rd = 1; cyc(); reg_rd = 0; v = reg_rdata;
  endtask

  // Runs one tenure; reports the cycle of the first release (-1 if none) and pulse count.
  task automatic tenure(input int start, input int limit, output int first, output int pulses);
    stop = 0; grant_rise = 1; xfer = 0; cyc(); grant_rise = 0;
    first = -1; pulses = 0;
    if (release_req) pulses++;
    for (int c = 1; c <= limit; c++) begin
      xfer = 1; xfer_addr = 8'(start + c - 1); cyc();
      if (release_req) begin pulses++; if (first < 0) first = c; end
    end
    xfer = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc_cnt++;
      if (cyc_cnt > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual %0d expected <150000", cyc_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int v, first, pulses, len, expc, j;
    rst = 1; sw_rst = 0; stop = 0; dmaplus_mode = 0; test_en = 0; reg_wr = 0; reg_rd = 0;
    reg_wdata = 0; lb_en = 0; lb_sel = 0; grant_rise = 0; xfer = 0; xfer_addr = 0;
    cyc(); cyc(); rst = 0; cyc();
    chk("R1 release_req after reset", release_req, 0);
    chk("R1 prog_err after reset", prog_err, 0);
    rd(v); chk("R1 count after reset", v, 16);

    // R2: write with stop clear is ignored
    stop = 0; reg_wr = 1; reg_wdata = 7; cyc(); reg_wr = 0;
    rd(v); chk("R2 ignored write", v, 16);
    // R3: read with stop clear leaves reg_rdata unchanged
    wr(9); stop = 0; reg_rd = 1; cyc(); reg_rd = 0;
    chk("R3 read gated by stop", reg_rdata, 16);
    rd(v); chk("R3 live read", v, 9);

    // R4: clamp and flag
    lb_en = 1; wr(2); chk("R4 prog_err on small value", prog_err, 1);
    rd(v); chk("R4 clamped value", v, 4);
    lb_en = 0; wr(2); chk("R4 prog_err cleared", prog_err, 0);
    rd(v); chk("R4 unclamped value", v, 2);

    // R5: test mode decrement, budget kept
    wr(10); test_en = 1; wr(16'hFFFF); wr(0); test_en = 0;
    rd(v); chk("R5 test-mode decrement", v, 8);
    stop = 0; grant_rise = 1; cyc(); grant_rise = 0;
    rd(v); chk("R6 reload from budget", v, 10);
    wr(0); test_en = 1; wr(5); test_en = 0;
    rd(v); chk("R5 decrement stops at zero", v, 0);

    // R1: soft reset
    lb_en = 1; wr(1); sw_rst = 1; cyc(); sw_rst = 0;
    chk("R1 soft reset clears prog_err", prog_err, 0);
    rd(v); chk("R1 soft reset count", v, 16);

    // R7..R10: tenure sweep
    for (int lb = 0; lb < 2; lb++)
      for (int sel = 0; sel < 3; sel++)
        for (int n = 4; n <= 12; n++)
          for (int s = 0; s < 8; s++) begin
            lb_en = lb[0]; lb_sel = 2'(sel);
            len = 2 << sel;
            wr(16'(n));
            j = n;
            while (lb_en && (((s + j) % len) != 0)) j++;
            expc = j + 1;
            tenure(s, expc + 3, first, pulses);
            chk(lb_en ? "R9 release at aligned address" : "R8 release at count zero", first, expc);
            chk("R10 single pulse", pulses, 1);
            if (lb == 0 && sel == 0 && s == 0) begin
              rd(v); chk("R7 count after transfers", v, 0);
            end
          end

    // R9: select 3 behaves as length 8
    lb_en = 1; lb_sel = 2'd3; wr(5); tenure(1, 12, first, pulses);
    chk("R9 select 3 as length 8", first, 8);

    // R10: no release without a new grant after the tenure closes
    stop = 0; xfer = 1; xfer_addr = 0;
    pulses = 0;
    for (int k = 0; k < 10; k++) begin cyc(); if (release_req) pulses++; end
    xfer = 0;
    chk("R10 no release after tenure closed", pulses, 0);

    // R11: disable mode
    dmaplus_mode = 1;
    for (int lb = 0; lb < 2; lb++) begin
      lb_en = lb[0]; lb_sel = 0; wr(4);
      tenure(0, 20, first, pulses);
      chk("R11 no release when disabled", pulses, 0);
    end
    dmaplus_mode = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end
endmodule